// File: doc/BRIEF.md
# Interlocked Bit Test-and-Set Unit

This block sits on the memory side of two processor requesters and performs an atomic-style bit test-and-set on a 32-bit memory word. A requester presents a word address, a bit index and a mode flag and holds them until the block acknowledges. The block reads the word, notes whether the selected bit was already 1, and writes the word back with that bit forced to 1. The acknowledge carries the bit's earlier value, so the requester can branch on it: 0 means the bit was free and the requester now owns it, 1 means it was already taken.

In interlocked mode the block takes a global memory lock when it reads and releases it with the write. While the lock is held, the other requester's read is held back, so two interlocked operations never overlap. In plain mode the read and the write are ordinary, separate memory accesses. The other requester's read can fall between them, and both requesters can then see the bit as 0. The block keeps this race as it is. All memory traffic goes through one single-port synchronous memory, which returns read data in the cycle after the read.

Top module: `btas_unit`

## Requirements
- R1: After reset, both acknowledges are low and no memory access is driven (`mem_en` low).
- R2: An uncontended request, in either mode, issues its read in the cycle the request is first presented, its write two cycles later, and raises its acknowledge in the fourth cycle. The memory trace for it is one read followed by one write.
- R3: The write goes to the requested word with bit `req_bit` (0 = LSB) forced to 1. Every other bit is written back with the value that was read.
- R4: `ack_was_set` shows the value the selected bit had when it was read: 0 for clear, 1 for already set.
- R5: The acknowledge stays high for exactly one cycle. The requester drops its request in that cycle.
- R6: An interlocked operation holds the lock from its read through its write. While the lock is held, the other requester performs no read, in either mode. Two interlocked requests to the same clear bit therefore give exactly one 0 and one 1, and two such requests to different bits of one word leave both bits set.
- R7: When both requesters compete for the memory in the same cycle, a round-robin pointer decides. Requester 0 wins the first conflict after reset, and each conflict hands priority to the loser.
- R8: Two plain-mode requests presented together to the same clear bit both read before either writes (trace read, read, write, write), and both report 0.
- R9: At most one requester is granted the memory in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 2 | Per-requester request, held until acknowledged |
| req_locked | input | 2 | Per-requester mode: 1 = interlocked, 0 = plain |
| req_addr | input | 2x8 | Per-requester word address |
| req_bit | input | 2x5 | Per-requester bit index within the word |
| ack | output | 2 | Per-requester one-cycle acknowledge |
| ack_was_set | output | 2 | Prior value of the tested bit, valid with ack |
| mem_en | output | 1 | Memory access strobe |
| mem_wr | output | 1 | Write when 1, read when 0 (with mem_en) |
| mem_addr | output | 8 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read |

## Verification
The hardest cases to reach are the interleavings. One is the plain-mode race, where the second read must land between the first requester's read and its write. The other is the case where a lock blocks a request that arrived in the very same cycle. The bench presents both requests on the same clock edge, so the arbiter sees a real conflict. It records the order of reads and writes on the memory port together with the acknowledge cycles. Because the round-robin pointer carries over between scenarios, the scenarios run in a fixed order, and each one states which requester should win its conflict.

// File: rtl/btas_pkg.sv
package btas_pkg;

    localparam int NREQ   = 2;
    localparam int IDX_W  = $clog2(NREQ);
    localparam int ADDR_W = 8;
    localparam int WORD_W = 32;
    localparam int BIT_W  = $clog2(WORD_W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TEST,
        ST_WRITE,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bitn;
        logic              locked;
    } op_t;

    function automatic logic [WORD_W-1:0] bit_onehot(input logic [BIT_W-1:0] b);
        return WORD_W'(1) << b;
    endfunction

endpackage

// File: rtl/btas_port_seq.sv
module btas_port_seq
    import btas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  op_t               op_in,
    input  logic              grant,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              want_rd,
    output logic              want_wr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              cur_locked,
    output logic [WORD_W-1:0] wdata,
    output logic              ack,
    output logic              ack_was_set
);

    seq_state_e        state;
    op_t               op_q;
    logic [WORD_W-1:0] word_q;
    logic              prior_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            op_q    <= '0;
            word_q  <= '0;
            prior_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (req && grant) begin
                        op_q  <= op_in;
                        state <= ST_TEST;
                    end
                end
                ST_TEST: begin
                    word_q  <= mem_rdata | bit_onehot(op_q.bitn);
                    prior_q <= mem_rdata[op_q.bitn];
                    state   <= ST_WRITE;
                end
                ST_WRITE: begin
                    if (grant) state <= ST_DONE;
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Before the read is granted the live request drives the address.
    assign cur_addr    = (state == ST_IDLE) ? op_in.addr   : op_q.addr;
    assign cur_locked  = (state == ST_IDLE) ? op_in.locked : op_q.locked;
    assign want_rd     = (state == ST_IDLE) && req;
    assign want_wr     = (state == ST_WRITE);
    assign wdata       = word_q;
    assign ack         = (state == ST_DONE);
    assign ack_was_set = prior_q;

endmodule

// File: rtl/btas_lock_ctl.sv
module btas_lock_ctl
    import btas_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  grant,
    input  logic [NREQ-1:0]  want_rd,
    input  logic [NREQ-1:0]  want_wr,
    input  logic [NREQ-1:0]  locked,
    output logic             lock_vld,
    output logic [IDX_W-1:0] lock_own
);

    logic             acquire;
    logic [IDX_W-1:0] acq_idx;
    logic             release_lk;

    always_comb begin
        acquire = 1'b0;
        acq_idx = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i] && want_rd[i] && locked[i]) begin
                acquire = 1'b1;
                acq_idx = IDX_W'(i);
            end
        end
        release_lk = lock_vld && grant[lock_own] && want_wr[lock_own];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_vld <= 1'b0;
            lock_own <= '0;
        end else if (acquire) begin
            lock_vld <= 1'b1;
            lock_own <= acq_idx;
        end else if (release_lk) begin
            lock_vld <= 1'b0;
        end
    end

endmodule

// File: rtl/btas_bus_arb.sv
module btas_bus_arb
    import btas_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NREQ-1:0]  want_rd,
    input  logic [NREQ-1:0]  want_wr,
    input  logic             lock_vld,
    input  logic [IDX_W-1:0] lock_own,
    output logic [NREQ-1:0]  grant
);

    logic [NREQ-1:0] eligible;
    logic            favour_q;
    logic            conflict;

    for (genvar i = 0; i < NREQ; i++) begin : g_elig
        assign eligible[i] = want_wr[i] |
                             (want_rd[i] & (!lock_vld || lock_own == IDX_W'(i)));
    end

    assign conflict = &eligible;

    always_comb begin
        grant = eligible;
        if (conflict) begin
            grant           = '0;
            grant[favour_q] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)           favour_q <= 1'b0;
        else if (conflict) favour_q <= ~favour_q;
    end

endmodule

// File: rtl/btas_unit.sv
module btas_unit
    import btas_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NREQ-1:0]             req_valid,
    input  logic [NREQ-1:0]             req_locked,
    input  logic [NREQ-1:0][ADDR_W-1:0] req_addr,
    input  logic [NREQ-1:0][BIT_W-1:0]  req_bit,
    output logic [NREQ-1:0]             ack,
    output logic [NREQ-1:0]             ack_was_set,
    output logic                        mem_en,
    output logic                        mem_wr,
    output logic [ADDR_W-1:0]           mem_addr,
    output logic [WORD_W-1:0]           mem_wdata,
    input  logic [WORD_W-1:0]           mem_rdata
);

    logic [NREQ-1:0]   grant;
    logic [NREQ-1:0]   want_rd;
    logic [NREQ-1:0]   want_wr;
    logic [NREQ-1:0]   locked_vec;
    logic [ADDR_W-1:0] cur_addr [NREQ];
    logic [WORD_W-1:0] wdata    [NREQ];
    logic              lock_vld;
    logic [IDX_W-1:0]  lock_own;

    for (genvar i = 0; i < NREQ; i++) begin : g_port
        op_t op_in;
        assign op_in = '{addr: req_addr[i], bitn: req_bit[i], locked: req_locked[i]};

        btas_port_seq u_seq (
            .clk         (clk),
            .rst         (rst),
            .req         (req_valid[i]),
            .op_in       (op_in),
            .grant       (grant[i]),
            .mem_rdata   (mem_rdata),
            .want_rd     (want_rd[i]),
            .want_wr     (want_wr[i]),
            .cur_addr    (cur_addr[i]),
            .cur_locked  (locked_vec[i]),
            .wdata       (wdata[i]),
            .ack         (ack[i]),
            .ack_was_set (ack_was_set[i])
        );
    end

    btas_lock_ctl u_lock (
        .clk      (clk),
        .rst      (rst),
        .grant    (grant),
        .want_rd  (want_rd),
        .want_wr  (want_wr),
        .locked   (locked_vec),
        .lock_vld (lock_vld),
        .lock_own (lock_own)
    );

    btas_bus_arb u_arb (
        .clk      (clk),
        .rst      (rst),
        .want_rd  (want_rd),
        .want_wr  (want_wr),
        .lock_vld (lock_vld),
        .lock_own (lock_own),
        .grant    (grant)
    );

    always_comb begin
        mem_en    = |grant;
        mem_wr    = |(grant & want_wr);
        mem_addr  = '0;
        mem_wdata = '0;
        for (int i = 0; i < NREQ; i++) begin
            if (grant[i]) begin
                mem_addr  = cur_addr[i];
                mem_wdata = wdata[i];
            end
        end
    end

endmodule

// File: rtl/btas_unit_chk.sv
module btas_unit_chk
    import btas_pkg::*;
(
    input logic                        clk,
    input logic                        rst,
    input logic [NREQ-1:0]             ack,
    input logic [NREQ-1:0][ADDR_W-1:0] req_addr,
    input logic [NREQ-1:0][BIT_W-1:0]  req_bit,
    input logic                        mem_en,
    input logic                        mem_wr,
    input logic [ADDR_W-1:0]           mem_addr,
    input logic [WORD_W-1:0]           mem_wdata,
    input logic [NREQ-1:0]             grant,
    input logic                        lock_vld,
    input logic [IDX_W-1:0]            lock_own
);

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (rst) $onehot0(grant)); // R9

    AST_LOCK_BLOCKS_RD0: assert property (@(posedge clk) disable iff (rst)
        (lock_vld && grant[0] && !mem_wr) |-> (lock_own == 1'b0)); // R6

    AST_LOCK_BLOCKS_RD1: assert property (@(posedge clk) disable iff (rst)
        (lock_vld && grant[1] && !mem_wr) |-> (lock_own == 1'b1)); // R6

    AST_ACK_PULSE0: assert property (@(posedge clk) disable iff (rst) ack[0] |=> !ack[0]); // R5

    AST_ACK_PULSE1: assert property (@(posedge clk) disable iff (rst) ack[1] |=> !ack[1]); // R5

    AST_ACK_AFTER_SET0: assert property (@(posedge clk) disable iff (rst)
        ack[0] |-> $past(mem_en && mem_wr && mem_addr == req_addr[0] && mem_wdata[req_bit[0]])); // R3

    AST_ACK_AFTER_SET1: assert property (@(posedge clk) disable iff (rst)
        ack[1] |-> $past(mem_en && mem_wr && mem_addr == req_addr[1] && mem_wdata[req_bit[1]])); // R3

    AST_ACCESS_HAS_GRANT: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (grant != '0)); // R9

endmodule

bind btas_unit btas_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .ack       (ack),
    .req_addr  (req_addr),
    .req_bit   (req_bit),
    .mem_en    (mem_en),
    .mem_wr    (mem_wr),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .grant     (grant),
    .lock_vld  (lock_vld),
    .lock_own  (lock_own)
);

// File: tb/tb_btas_unit.sv
`timescale 1ns/1ps
module tb_btas_unit;
    import btas_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NREQ-1:0]             req_valid = '0;
    logic [NREQ-1:0]             req_locked = '0;
    logic [NREQ-1:0][ADDR_W-1:0] req_addr = '0;
    logic [NREQ-1:0][BIT_W-1:0]  req_bit = '0;
    logic [NREQ-1:0]             ack;
    logic [NREQ-1:0]             ack_was_set;
    logic                        mem_en;
    logic                        mem_wr;
    logic [ADDR_W-1:0]           mem_addr;
    logic [WORD_W-1:0]           mem_wdata;
    logic [WORD_W-1:0]           mem_rdata = '0;

    logic [WORD_W-1:0] mem_arr [1<<ADDR_W];

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    // single-port synchronous memory, read data one cycle later
    always @(posedge clk) begin
        if (mem_en) begin
            mem_rdata <= mem_arr[mem_addr];
            if (mem_wr) mem_arr[mem_addr] <= mem_wdata;
        end
    end

    btas_unit dut (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_locked  (req_locked),
        .req_addr    (req_addr),
        .req_bit     (req_bit),
        .ack         (ack),
        .ack_was_set (ack_was_set),
        .mem_en      (mem_en),
        .mem_wr      (mem_wr),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata),
        .mem_rdata   (mem_rdata)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic check_str(input string tag, input string what,
                             input string act, input string exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %s expected %s", tag, what, act, exp);
        end
    endtask

    // Present requests on one edge; record the memory trace and acks.
    task automatic run_ops(input logic [1:0] use_v, input logic [1:0] lk,
                           input logic [ADDR_W-1:0] a0, input logic [ADDR_W-1:0] a1,
                           input logic [BIT_W-1:0] b0, input logic [BIT_W-1:0] b1,
                           output int lat0, output int lat1,
                           output logic s0, output logic s1, output string trace);
        lat0 = -1; lat1 = -1; s0 = 1'bx; s1 = 1'bx; trace = "";
        @(negedge clk);
        req_locked  = lk;
        req_addr[0] = a0; req_addr[1] = a1;
        req_bit[0]  = b0; req_bit[1]  = b1;
        req_valid   = use_v;
        for (int k = 0; k < 40; k++) begin
            #1;
            if (mem_en) trace = {trace, mem_wr ? "W" : "R"};
            if (use_v[0] && lat0 < 0 && ack[0]) begin
                lat0 = k; s0 = ack_was_set[0]; req_valid[0] = 1'b0;
            end
            if (use_v[1] && lat1 < 0 && ack[1]) begin
                lat1 = k; s1 = ack_was_set[1]; req_valid[1] = 1'b0;
            end
            if ((!use_v[0] || lat0 >= 0) && (!use_v[1] || lat1 >= 0)) break;
            @(negedge clk);
        end
        @(negedge clk);
        #1;
        check(ack == '0, "R5", "ack low one cycle after acknowledge", ack, 0);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        check(ack == '0, "R1", "ack after reset", ack, 0);
        check(mem_en == 1'b0, "R1", "mem_en after reset", mem_en, 0);
    endtask

    task automatic t_single_clear();
        int l0, l1; logic s0, s1; string tr;
        mem_arr[3] = 32'h0000_1000;
        run_ops(2'b01, 2'b01, 8'd3, 8'd0, 5'd5, 5'd0, l0, l1, s0, s1, tr);
        check(l0 == 3, "R2", "interlocked latency", l0, 3);
        check_str("R2", "single trace", tr, "RW");
        check(s0 == 1'b0, "R4", "prior clear", s0, 0);
        check(mem_arr[3] == 32'h0000_1020, "R3", "word after set", mem_arr[3], 32'h1020);
    endtask

    task automatic t_single_set();
        int l0, l1; logic s0, s1; string tr;
        mem_arr[7] = 32'h8000_0001;
        run_ops(2'b10, 2'b00, 8'd0, 8'd7, 5'd0, 5'd31, l0, l1, s0, s1, tr);
        check(l1 == 3, "R2", "plain latency", l1, 3);
        check(s1 == 1'b1, "R4", "prior set", s1, 1);
        check(mem_arr[7] == 32'h8000_0001, "R3", "word kept", mem_arr[7], 32'h8000_0001);
    endtask

    task automatic t_lock_pair(input logic exp_first, input logic [ADDR_W-1:0] a,
                               input logic [BIT_W-1:0] b);
        int l0, l1; logic s0, s1; string tr;
        mem_arr[a] = '0;
        run_ops(2'b11, 2'b11, a, a, b, b, l0, l1, s0, s1, tr);
        check_str("R6", "interlocked pair trace", tr, "RWRW");
        check((s0 ^ s1) == 1'b1, "R6", "exactly one clear", {s0, s1}, 1);
        check(exp_first ? s1 == 1'b0 : s0 == 1'b0, "R7", "conflict winner sees clear",
              {s1, s0}, exp_first ? 2'b10 : 2'b01);
        check(exp_first ? (l1 == 3 && l0 == 6) : (l0 == 3 && l1 == 6), "R7",
              "ack order", l0 * 16 + l1, exp_first ? 16'h63 : 16'h36);
        check(mem_arr[a] == bit_onehot(b), "R3", "pair word", mem_arr[a], bit_onehot(b));
    endtask

    task automatic t_plain_race();
        int l0, l1; logic s0, s1; string tr;
        mem_arr[12] = '0;
        run_ops(2'b11, 2'b00, 8'd12, 8'd12, 5'd4, 5'd4, l0, l1, s0, s1, tr);
        check_str("R8", "plain race trace", tr, "RRWW");
        check(s0 == 1'b0 && s1 == 1'b0, "R8", "both see clear", {s1, s0}, 0);
        check(l0 == 3 && l1 == 4, "R7", "plain ack order", l0 * 16 + l1, 16'h34);
        check(mem_arr[12] == 32'h10, "R3", "race word", mem_arr[12], 32'h10);
    endtask

    task automatic t_lock_diff_bits();
        int l0, l1; logic s0, s1; string tr;
        mem_arr[13] = '0;
        run_ops(2'b11, 2'b11, 8'd13, 8'd13, 5'd2, 5'd3, l0, l1, s0, s1, tr);
        check_str("R6", "diff-bit trace", tr, "RWRW");
        check(s0 == 1'b0 && s1 == 1'b0, "R4", "both bits were clear", {s1, s0}, 0);
        check(mem_arr[13] == 32'hC, "R6", "both bits kept", mem_arr[13], 32'hC);
        check(l1 == 3 && l0 == 6, "R7", "requester 1 favoured", l0 * 16 + l1, 16'h63);
    endtask

    task automatic t_mixed();
        int l0, l1; logic s0, s1; string tr;
        mem_arr[14] = '0;
        run_ops(2'b11, 2'b01, 8'd14, 8'd14, 5'd1, 5'd1, l0, l1, s0, s1, tr);
        check_str("R6", "lock blocks plain read", tr, "RWRW");
        check(s0 == 1'b0 && s1 == 1'b1, "R6", "plain sees set", {s1, s0}, 2'b10);
        check(l0 == 3 && l1 == 6, "R2", "mixed ack cycles", l0 * 16 + l1, 16'h36);
    endtask

    initial begin
        for (int i = 0; i < (1 << ADDR_W); i++) mem_arr[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_clear();
        t_single_set();
        t_lock_pair(1'b0, 8'd10, 5'd0);   // first conflict: requester 0
        t_lock_pair(1'b1, 8'd11, 5'd9);   // second conflict: requester 1
        t_plain_race();                    // third conflict: requester 0
        t_lock_diff_bits();                // fourth conflict: requester 1
        t_mixed();                         // fifth conflict: requester 0
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule